// File: doc/BRIEF.md
# DRAM Refresh Request Generator

The block keeps DRAM contents alive by issuing refresh bus cycles on its own. A down-counter runs against a programmable interval while the unit is enabled and at least one DRAM bank is switched on. Each expiry raises a refresh request, which stays up until the bus arbiter grants the bus. The block then runs a CAS-before-RAS refresh cycle of exactly seven clocks. The cycle length does not depend on the DRAM wait-state setting.

While the cycle runs, the block drives all ones onto the 16-bit address/data bus and forces the hidden upper four address bits high. The internal 20-bit address therefore reads as all ones. An activity flag marks the seven clocks so that chip-select decode and the arbiter can tell a refresh apart from a normal access. Arbitration beyond the request/grant pair and bank decoding belong to the surrounding logic.

The sequencer has six states. It leaves `RF_IDLE` for `RF_CAS_LEAD` when a pending request is granted. It then steps `RF_CAS_LEAD` → `RF_BOTH` (held for three clocks) → `RF_RAS_TAIL` → `RF_PRECHG` → `RF_RECOVER` → `RF_IDLE`, one state per clock and without conditions, apart from the three-clock hold in `RF_BOTH`.

Top module: `dram_refresh_gen`

## Requirements
- R1: The unit runs only while `enable` is 1 and at least one bit of `bank_en` is 1. If either condition fails on a clock edge, any pending request is dropped at that edge and no new request is raised.
- R2: Take interval value N. The first request appears N+1 clocks after the unit starts running, and the counter reloads N each time it reaches zero. The count is reloaded continuously while the unit is not running.
- R3: A raised request stays at 1 until it is sampled together with `bus_grant` = 1. The refresh cycle starts on that edge.
- R4: Every refresh cycle holds `refresh_active` at 1 for exactly 7 clocks, followed by at least one idle clock.
- R5: The strobes are active-low. `cas_n` is 0 in clocks 1–4. `ras_n` is 0 in clocks 2–5. Both are 1 in clocks 6–7, so CAS falls before RAS and rises while RAS is still low.
- R6: During the cycle, `ad_out` = FFFFh, `addr_hi` = Fh and `ad_oe` = 1. When idle, all three are 0.
- R7: The request is 0 while a cycle is active, and at most one request is outstanding. With the grant held at 1, cycles start every max(N+1, 8) clocks.
- R8: Dropping `enable` during a cycle does not shorten it. The cycle still runs all 7 clocks.
- R9: While reset is active, `refresh_req` = 0, `refresh_active` = 0, both strobes are 1 and `ad_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Refresh unit enable |
| bank_en | input | BANKS | Per-bank DRAM enabled flags |
| interval | input | CNT_W | Refresh interval count N |
| bus_grant | input | 1 | Bus granted to refresh |
| refresh_req | output | 1 | Refresh bus request |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ad_out | output | BUS_W | Address/data bus value |
| ad_oe | output | 1 | Bus drive enable |
| addr_hi | output | UPPER_W | Internal upper address bits |
| refresh_active | output | 1 | Refresh cycle in progress |

## Verification
The bench sweeps every interval from 0 to 12. For each one it measures the delay to the first request and the spacing between cycles with the grant held high. That sweep covers the point where spacing switches from interval-limited to cycle-length-limited. An off-by-one in the reload would shift every delay by one clock, and a request that overlaps a running cycle would show spacing below 8. The bench also checks the strobe pattern clock by clock, so a swapped CAS/RAS order or a cycle that is one clock long or short fails at once. Separate checks cover a request that waits through a long denied grant, a request dropped when the enable or the last bank goes away, each bank enabling the unit alone, and a disable in mid-cycle. A design that aborts the cycle on disable, or leaves the request latched, would fail those checks.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        RF_IDLE     = 3'd0,
        RF_CAS_LEAD = 3'd1,
        RF_BOTH     = 3'd2,
        RF_RAS_TAIL = 3'd3,
        RF_PRECHG   = 3'd4,
        RF_RECOVER  = 3'd5
    } rf_state_e;

    // clocks spent with both strobes low
    localparam int unsigned RF_BOTH_CLKS  = 3;
    // whole cycle: lead + both + tail + precharge + recovery
    localparam int unsigned RF_CYCLE_CLKS = 1 + RF_BOTH_CLKS + 3;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] interval,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || (cnt_q == '0)) begin
            cnt_q <= interval;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/refresh_request_latch.sv
module refresh_request_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic expire,
    input  logic idle,
    input  logic grant,
    output logic req,
    output logic start
);

    logic pending_q;

    // a request is only shown while the sequencer can accept it
    assign req   = pending_q && idle;
    assign start = req && grant;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (!run) begin
            pending_q <= 1'b0;
        end else if (expire) begin
            pending_q <= 1'b1;
        end else if (start) begin
            pending_q <= 1'b0;
        end
    end

endmodule

// File: rtl/refresh_cycle_fsm.sv
module refresh_cycle_fsm
    import dram_refresh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output rf_state_e state,
    output logic      idle
);

    localparam int unsigned HOLD_W = (RF_BOTH_CLKS > 1) ? $clog2(RF_BOTH_CLKS) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RF_BOTH_CLKS - 1);

    rf_state_e         state_d;
    logic [HOLD_W-1:0] hold_q;

    assign idle = (state == RF_IDLE);

    always_comb begin
        state_d = state;
        unique case (state)
            RF_IDLE:     if (start) state_d = RF_CAS_LEAD;
            RF_CAS_LEAD: state_d = RF_BOTH;
            RF_BOTH:     if (hold_q == HOLD_LAST) state_d = RF_RAS_TAIL;
            RF_RAS_TAIL: state_d = RF_PRECHG;
            RF_PRECHG:   state_d = RF_RECOVER;
            RF_RECOVER:  state_d = RF_IDLE;
            default:     state_d = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RF_IDLE;
            hold_q <= '0;
        end else begin
            state  <= state_d;
            hold_q <= (state == RF_BOTH) ? hold_q + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/refresh_bus_drive.sv
module refresh_bus_drive
    import dram_refresh_pkg::*;
#(
    parameter int unsigned BUS_W   = 16,
    parameter int unsigned UPPER_W = 4
) (
    input  rf_state_e          state,
    output logic               ras_n,
    output logic               cas_n,
    output logic [BUS_W-1:0]   ad_out,
    output logic               ad_oe,
    output logic [UPPER_W-1:0] addr_hi,
    output logic               active
);

    always_comb begin
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        ad_out  = '1;
        ad_oe   = 1'b1;
        addr_hi = '1;
        active  = 1'b1;
        unique case (state)
            RF_IDLE: begin
                ad_out  = '0;
                ad_oe   = 1'b0;
                addr_hi = '0;
                active  = 1'b0;
            end
            RF_CAS_LEAD: cas_n = 1'b0;
            RF_BOTH: begin
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            RF_RAS_TAIL: ras_n = 1'b0;
            RF_PRECHG:   ;
            RF_RECOVER:  ;
            default: begin
                ad_out  = '0;
                ad_oe   = 1'b0;
                addr_hi = '0;
                active  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dram_refresh_gen.sv
module dram_refresh_gen
    import dram_refresh_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned BANKS   = 2,
    parameter int unsigned BUS_W   = 16,
    parameter int unsigned UPPER_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [BANKS-1:0]   bank_en,
    input  logic [CNT_W-1:0]   interval,
    input  logic               bus_grant,
    output logic               refresh_req,
    output logic               ras_n,
    output logic               cas_n,
    output logic [BUS_W-1:0]   ad_out,
    output logic               ad_oe,
    output logic [UPPER_W-1:0] addr_hi,
    output logic               refresh_active
);

    logic      run;
    logic      expire;
    logic      idle;
    logic      start;
    rf_state_e state;

    assign run = enable && (|bank_en);

    refresh_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .interval (interval),
        .expire   (expire)
    );

    refresh_request_latch u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .expire (expire),
        .idle   (idle),
        .grant  (bus_grant),
        .req    (refresh_req),
        .start  (start)
    );

    refresh_cycle_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .idle  (idle)
    );

    refresh_bus_drive #(.BUS_W(BUS_W), .UPPER_W(UPPER_W)) u_drive (
        .state   (state),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .addr_hi (addr_hi),
        .active  (refresh_active)
    );

endmodule

// File: rtl/dram_refresh_gen_chk.sv
module dram_refresh_gen_chk #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned BANKS   = 2,
    parameter int unsigned BUS_W   = 16,
    parameter int unsigned UPPER_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [BANKS-1:0]   bank_en,
    input logic [CNT_W-1:0]   interval,
    input logic               bus_grant,
    input logic               refresh_req,
    input logic               ras_n,
    input logic               cas_n,
    input logic [BUS_W-1:0]   ad_out,
    input logic               ad_oe,
    input logic [UPPER_W-1:0] addr_hi,
    input logic               refresh_active
);

    logic       run_c;
    logic [3:0] act_len;

    assign run_c = enable && (|bank_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              act_len <= '0;
        else if (refresh_active) act_len <= act_len + 1'b1;
        else                     act_len <= '0;
    end

    p_no_req_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_c |=> !refresh_req);

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && !bus_grant && run_c) |=> refresh_req);

    p_grant_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && bus_grant) |=> (refresh_active && !refresh_req));

    p_cycle_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_active) |-> (act_len == 4'd7));

    p_cycle_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_active |-> (act_len < 4'd7));

    p_cas_before_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    p_cas_rel_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> !ras_n);

    p_bus_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_active |-> (ad_oe && (&ad_out) && (&addr_hi)));

    p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_active |-> (!ad_oe && ras_n && cas_n));

    p_no_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> !refresh_active);

endmodule

bind dram_refresh_gen dram_refresh_gen_chk #(
    .CNT_W(CNT_W), .BANKS(BANKS), .BUS_W(BUS_W), .UPPER_W(UPPER_W)
) u_chk (.*);

// File: tb/dram_refresh_gen_tb.sv
`timescale 1ns/1ps
module dram_refresh_gen_tb;

    localparam int CNT_W   = 16;
    localparam int BANKS   = 2;
    localparam int BUS_W   = 16;
    localparam int UPPER_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               enable = 1'b0;
    logic [BANKS-1:0]   bank_en = '0;
    logic [CNT_W-1:0]   interval = '0;
    logic               bus_grant = 1'b0;
    logic               refresh_req;
    logic               ras_n;
    logic               cas_n;
    logic [BUS_W-1:0]   ad_out;
    logic               ad_oe;
    logic [UPPER_W-1:0] addr_hi;
    logic               refresh_active;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_gen #(.CNT_W(CNT_W), .BANKS(BANKS), .BUS_W(BUS_W), .UPPER_W(UPPER_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bank_en(bank_en),
        .interval(interval), .bus_grant(bus_grant), .refresh_req(refresh_req),
        .ras_n(ras_n), .cas_n(cas_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .refresh_active(refresh_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic arm(input int n, input logic [BANKS-1:0] banks);
        @(negedge clk);
        enable    = 1'b0;
        bus_grant = 1'b0;
        interval  = CNT_W'(n);
        bank_en   = banks;
        repeat (10) @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic wait_req(output int k);
        k = 0;
        while (k < 60) begin
            @(negedge clk);
            k++;
            if (refresh_req) break;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 req in reset", refresh_req, 0);
        chk("R9 active in reset", refresh_active, 0);
        chk("R9 ras_n in reset", ras_n, 1);
        chk("R9 cas_n in reset", cas_n, 1);
        chk("R9 ad_oe in reset", ad_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 req after reset", refresh_req, 0);

        // R2, R4, R5, R6, R7: sweep of intervals
        for (int n = 0; n <= 12; n++) begin
            int t;
            arm(n, 2'b11);
            wait_req(k);
            chk("R2 first request delay", k, n + 1);
            bus_grant = 1'b1;
            @(negedge clk);
            for (int i = 0; i < 7; i++) begin
                if (i > 0) @(negedge clk);
                chk("R4 active inside cycle", refresh_active, 1);
                chk("R5 cas_n pattern", cas_n, (i < 4) ? 1'b0 : 1'b1);
                chk("R5 ras_n pattern", ras_n, (i >= 1 && i <= 4) ? 1'b0 : 1'b1);
                chk("R6 bus all ones", ad_out, 16'hFFFF);
                chk("R6 upper bits ones", addr_hi, 4'hF);
                chk("R6 bus driven", ad_oe, 1);
                chk("R7 no request while busy", refresh_req, 0);
            end
            @(negedge clk);
            chk("R4 cycle ends after 7", refresh_active, 0);
            chk("R6 bus released", ad_oe, 0);
            chk("R6 bus zero idle", ad_out, 0);
            t = 7;
            while (!refresh_active && t < 60) begin
                @(negedge clk);
                t++;
            end
            chk("R7 cycle spacing", t, (n + 1 > 8) ? n + 1 : 8);
            bus_grant = 1'b0;
        end

        // R3: request held through denied grant, single bank 0
        arm(3, 2'b01);
        wait_req(k);
        chk("R1 bank0 alone runs", k, 4);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R3 request held", refresh_req, 1);
            chk("R3 no cycle without grant", refresh_active, 0);
        end
        bus_grant = 1'b1;
        @(negedge clk);
        chk("R3 cycle starts on grant", refresh_active, 1);
        chk("R7 request drops on start", refresh_req, 0);
        bus_grant = 1'b0;

        // R1: losing the last bank drops the pending request
        wait_req(k);
        bank_en = 2'b00;
        @(negedge clk);
        chk("R1 request dropped no bank", refresh_req, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk("R1 silent without bank", {refresh_req, refresh_active}, 0);
        end
        bank_en = 2'b10;
        wait_req(k);
        chk("R1 bank1 alone runs", k, 4);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 request dropped on disable", refresh_req, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk("R1 silent when disabled", {refresh_req, refresh_active}, 0);
        end

        // R8: disable in mid-cycle
        arm(5, 2'b11);
        wait_req(k);
        bus_grant = 1'b1;
        @(negedge clk);
        chk("R8 cycle started", refresh_active, 1);
        enable    = 1'b0;
        bus_grant = 1'b0;
        for (int i = 1; i < 7; i++) begin
            @(negedge clk);
            chk("R8 cycle continues", refresh_active, 1);
        end
        @(negedge clk);
        chk("R8 cycle ends at 7", refresh_active, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R8 no request after disable", refresh_req, 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule